// File: doc/BRIEF.md
# Banked external memory address decoder

This block sits between a 16-bit CPU address bus and an external memory port. For each CPU address it drives three active-low chip selects: one for the general external window, one for RAM and one for ROM. It also drives a 19-bit external address bus. Two 8 KB windows in the upper half of the CPU map are banked. Inside either window, the upper external address bits come from a 6-bit page register, so the CPU can reach up to 512 KB of external storage.

Two merge bits widen the selects. RAM merge stretches the RAM select over the banked windows. ROM merge stretches the ROM select downward to the start of the banked windows. In every mode, a 256-byte hole at the base of the ROM region never asserts the ROM select. The four top address lines stay forced high until software sets an enable bit.

The decode path is purely combinational. The four control registers are written synchronously through a simple register port. That port also reads back their values combinationally.

Top module: `xmem_bank_decoder`

## Requirements
- R1: After reset, all four control registers read back as zero, and ext_addr[18:15] is 4'b1111.
- R2: While cpu_valid is low, mem_sel_n, ram_sel_n and rom_sel_n are all high, whatever the address.
- R3: With cpu_valid high, mem_sel_n is low exactly for addresses 0x8000 through 0xBFFF.
- R4: With cpu_valid high, ram_sel_n is low for 0x4000 through 0x7FFF. When RAM merge is set, it is also low for 0x8000 through 0xBFFF. RAM merge is bit 0 of the merge register at 0xC03A.
- R5: With cpu_valid high, rom_sel_n is low for 0xC100 through 0xDFFF. When ROM merge is set, it is also low for 0x8000 through 0xBFFF. ROM merge is bit 1 of the merge register. Addresses 0xC000 through 0xC0FF never assert rom_sel_n.
- R6: For addresses 0x8000 through 0x9FFF, ext_addr is {page_a, addr[12:0]}, where page_a is the 6-bit register at 0xC018. For 0xA000 through 0xBFFF, ext_addr uses page_b, the register at 0xC01A.
- R7: Outside the two banked windows, ext_addr[14:0] equals addr[14:0] and ext_addr[18:15] is zero, as long as the upper lines are enabled.
- R8: While bit 0 of the upper-enable register at 0xC03C is zero, ext_addr[18:15] is forced to 4'b1111. The other bits are unaffected.
- R9: A write strobe held for one cycle updates the addressed register at the next clock edge. Only the register's own width is stored (6 bits for a page, 2 for merge, 1 for enable), and read back zero-extended. A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_valid | input | 1 | High while a CPU access is in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address for write and read-back |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read-back of the register at reg_addr, zero if unmapped |
| mem_sel_n | output | 1 | General external window select, active low |
| ram_sel_n | output | 1 | RAM select, active low |
| rom_sel_n | output | 1 | ROM select, active low |
| ext_addr | output | 19 | External address bus |

## Verification
The bench runs the same list of boundary addresses under all four merge settings. The list includes both edges of each region, the hole and the space above ROM. This separates off-by-one region bounds, a missing hole and a merge bit wired to the wrong select. Distinct, non-symmetric page values in the two banked windows expose a swapped page register or a wrong split between page bits and offset bits. Repeating the sweep with the upper lines disabled, then enabled, shows the forced-high bits and the zero-filled flat mapping as separate effects.

// File: rtl/xmd_pkg.sv
package xmd_pkg;
  localparam int CPU_AW  = 16;
  localparam int EXT_AW  = 19;
  localparam int PAGE_W  = 6;
  localparam int OFF_W   = 13;
  localparam int NPAGE   = 2;
  localparam int DATA_W  = 16;

  // inclusive range test on a CPU address
  function automatic logic in_span(input logic [CPU_AW-1:0] a,
                                   input logic [CPU_AW-1:0] lo,
                                   input logic [CPU_AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // banked external address: page bits above window offset
  function automatic logic [EXT_AW-1:0] banked_addr(input logic [PAGE_W-1:0] pg,
                                                    input logic [OFF_W-1:0] off);
    return EXT_AW'({pg, off});
  endfunction
endpackage

// File: rtl/xmd_regs.sv
module xmd_regs
  import xmd_pkg::*;
#(
  parameter int AW = CPU_AW,
  parameter int DW = DATA_W,
  parameter int PW = PAGE_W,
  parameter int NP = NPAGE,
  parameter logic [AW-1:0] PAGE_BASE   = 16'hC018,
  parameter int            PAGE_STRIDE = 2,
  parameter logic [AW-1:0] MERGE_ADDR  = 16'hC03A,
  parameter logic [AW-1:0] UPEN_ADDR   = 16'hC03C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic [NP-1:0][PW-1:0] page_o,
  output logic                 ram_merge,
  output logic                 rom_merge,
  output logic                 upper_en
);
  logic [1:0] merge_q;
  logic       upen_q;
  logic [NP-1:0] page_hit;
  logic merge_hit, upen_hit;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DW-1:PW];

  assign merge_hit = (addr == MERGE_ADDR);
  assign upen_hit  = (addr == UPEN_ADDR);

  for (genvar g = 0; g < NP; g++) begin : g_page
    localparam logic [AW-1:0] REG_ADDR = AW'(PAGE_BASE + AW'(g * PAGE_STRIDE));
    assign page_hit[g] = (addr == REG_ADDR);

    always_ff @(posedge clk) begin
      if (!rst_n)                  page_o[g] <= '0;
      else if (wr && page_hit[g])  page_o[g] <= wdata[PW-1:0];
    end

    p_page_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && page_hit[g]) |=> (page_o[g] == $past(wdata[PW-1:0])));
    p_page_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && page_hit[g]) |=> $stable(page_o[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      merge_q <= '0;
      upen_q  <= 1'b0;
    end else if (wr) begin
      if (merge_hit) merge_q <= wdata[1:0];
      if (upen_hit)  upen_q  <= wdata[0];
    end
  end

  assign ram_merge = merge_q[0];
  assign rom_merge = merge_q[1];
  assign upper_en  = upen_q;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NP; i++)
      if (page_hit[i]) rdata = DW'(page_o[i]);
    if (merge_hit) rdata = DW'(merge_q);
    if (upen_hit)  rdata = DW'(upen_q);
  end
endmodule

// File: rtl/xmd_select.sv
module xmd_select
  import xmd_pkg::*;
#(
  parameter int AW = CPU_AW,
  parameter logic [AW-1:0] WIN_LO = 16'h8000,
  parameter logic [AW-1:0] WIN_HI = 16'hBFFF,
  parameter logic [AW-1:0] RAM_LO = 16'h4000,
  parameter logic [AW-1:0] RAM_HI = 16'h7FFF,
  parameter logic [AW-1:0] ROM_LO = 16'hC000,
  parameter logic [AW-1:0] ROM_HI = 16'hDFFF,
  parameter int            HOLE_BYTES = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          valid,
  input  logic          ram_merge,
  input  logic          rom_merge,
  output logic          mem_sel_n,
  output logic          ram_sel_n,
  output logic          rom_sel_n
);
  localparam logic [AW-1:0] HOLE_HI = AW'(ROM_LO + AW'(HOLE_BYTES - 1));

  logic in_win, in_ram_base, in_rom_base, in_hole;
  logic want_mem, want_ram, want_rom;

  assign in_win      = in_span(addr, WIN_LO, WIN_HI);
  assign in_ram_base = in_span(addr, RAM_LO, RAM_HI);
  assign in_rom_base = in_span(addr, ROM_LO, ROM_HI);
  assign in_hole     = in_span(addr, ROM_LO, HOLE_HI);

  assign want_mem = in_win;
  assign want_ram = in_ram_base || (ram_merge && in_win);
  assign want_rom = (in_rom_base && !in_hole) || (rom_merge && in_win);

  assign mem_sel_n = !(valid && want_mem);
  assign ram_sel_n = !(valid && want_ram);
  assign rom_sel_n = !(valid && want_rom);

  p_idle_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (mem_sel_n && ram_sel_n && rom_sel_n));
  p_mem_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sel_n |-> (addr[AW-1 -: 2] == 2'b10));
  p_ram_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel_n |-> (addr[AW-1 -: 2] == 2'b01 || (ram_merge && !mem_sel_n)));
  p_rom_hole_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[AW-1 -: 8] == 8'hC0) |-> rom_sel_n);
endmodule

// File: rtl/xmd_xaddr.sv
module xmd_xaddr
  import xmd_pkg::*;
#(
  parameter int AW = CPU_AW,
  parameter int EW = EXT_AW,
  parameter int PW = PAGE_W,
  parameter int OW = OFF_W,
  parameter int NP = NPAGE,
  parameter logic [AW-1:0] WIN_BASE = 16'h8000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr,
  input  logic [NP-1:0][PW-1:0] page,
  input  logic                  upper_en,
  output logic [EW-1:0]         ext_addr
);
  localparam int LOW_W = AW - 1;
  localparam int UP_W  = EW - LOW_W;
  localparam int SEL_W = AW - OW;
  localparam logic [SEL_W-1:0] BASE_IDX = WIN_BASE[AW-1:OW];

  logic [NP-1:0] win_hit;
  logic [EW-1:0] raw_addr;

  for (genvar g = 0; g < NP; g++) begin : g_win
    assign win_hit[g] = (addr[AW-1:OW] == SEL_W'(BASE_IDX + SEL_W'(g)));
  end

  always_comb begin
    raw_addr = EW'(addr[LOW_W-1:0]);
    for (int i = 0; i < NP; i++)
      if (win_hit[i]) raw_addr = banked_addr(page[i], addr[OW-1:0]);
  end

  always_comb begin
    ext_addr = raw_addr;
    if (!upper_en) ext_addr[EW-1:LOW_W] = {UP_W{1'b1}};
  end

  p_upper_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upper_en |-> (ext_addr[EW-1:LOW_W] == {UP_W{1'b1}}));
  p_bank_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit[0] && upper_en) |-> (ext_addr == {page[0], addr[OW-1:0]}));
  p_flat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit == '0 && upper_en) |-> (ext_addr[EW-1:LOW_W] == '0 && ext_addr[LOW_W-1:0] == addr[LOW_W-1:0]));
endmodule

// File: rtl/xmem_bank_decoder.sv
module xmem_bank_decoder
  import xmd_pkg::*;
#(
  parameter int AW = CPU_AW,
  parameter int EW = EXT_AW,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_valid,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_sel_n,
  output logic          ram_sel_n,
  output logic          rom_sel_n,
  output logic [EW-1:0] ext_addr
);
  logic [NPAGE-1:0][PAGE_W-1:0] page;
  logic ram_merge, rom_merge, upper_en;

  xmd_regs #(.AW(AW), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .page_o(page), .ram_merge(ram_merge),
    .rom_merge(rom_merge), .upper_en(upper_en)
  );

  xmd_select #(.AW(AW)) sel_i (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .valid(cpu_valid),
    .ram_merge(ram_merge), .rom_merge(rom_merge),
    .mem_sel_n(mem_sel_n), .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n)
  );

  xmd_xaddr #(.AW(AW), .EW(EW)) xaddr_i (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .page(page),
    .upper_en(upper_en), .ext_addr(ext_addr)
  );
endmodule

// File: tb/xmem_bank_decoder_tb_top.sv
`timescale 1ns/1ps
module xmem_bank_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0, reg_addr = '0, reg_wdata = '0;
  logic cpu_valid = 1'b0, reg_wr = 1'b0;
  logic [15:0] reg_rdata;
  logic mem_sel_n, ram_sel_n, rom_sel_n;
  logic [18:0] ext_addr;

  int checks = 0, errors = 0;
  bit done = 0;
  int sh_pa = 0, sh_pb = 0, sh_rm = 0, sh_om = 0, sh_ue = 0;

  logic [21:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  xmem_bank_decoder dut_i (.*);

  function automatic logic [21:0] model(int a, bit v);
    bit m, r, o;
    int e;
    m = v && a >= 32768 && a < 49152;
    r = v && ((a >= 16384 && a < 32768) || (sh_rm[0] && a >= 32768 && a < 49152));
    o = v && ((a >= 49408 && a < 57344) || (sh_om[0] && a >= 32768 && a < 49152));
    if (a / 8192 == 4)      e = sh_pa * 8192 + a % 8192;
    else if (a / 8192 == 5) e = sh_pb * 8192 + a % 8192;
    else                    e = a % 32768;
    if (!sh_ue[0]) e = e | (15 << 15);
    return {!m, !r, !o, e[18:0]};
  endfunction

  task automatic drive(int a, bit v, string tag);
    @(posedge clk); #1;
    cpu_addr = a[15:0];
    cpu_valid = v;
    exp_q.push_back(model(a, v));
    tag_q.push_back(tag);
  endtask

  // monitor: compares outputs half a cycle after each drive
  initial forever begin
    @(negedge clk);
    if (exp_q.size() > 0) begin
      logic [21:0] e, got;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = {mem_sel_n, ram_sel_n, rom_sel_n, ext_addr};
      checks++;
      if (got !== e) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", t, cpu_addr, got, e);
      end
    end
  end

  task automatic write_reg(int a, int d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a[15:0]; reg_wdata = d[15:0];
    @(posedge clk); #1;
    reg_wr = 0;
    if (a == 'hC018) sh_pa = d & 63;
    if (a == 'hC01A) sh_pb = d & 63;
    if (a == 'hC03A) begin sh_rm = d & 1; sh_om = (d >> 1) & 1; end
    if (a == 'hC03C) sh_ue = d & 1;
  endtask

  task automatic check_rd(int a, int exp, string tag);
    @(posedge clk); #1;
    reg_addr = a[15:0];
    @(negedge clk);
    checks++;
    if (reg_rdata !== exp[15:0]) begin
      errors++;
      $display("FAIL %s reg=%h actual=%h expected=%h", tag, a, reg_rdata, exp[15:0]);
    end
  endtask

  task automatic sweep(bit v, string tag);
    int pts[14] = '{'h0000, 'h3FFF, 'h4000, 'h7FFF, 'h8000, 'h9ABC, 'h9FFF,
                    'hA000, 'hB123, 'hBFFF, 'hC000, 'hC0FF, 'hC100, 'hDFFF};
    foreach (pts[i]) drive(pts[i], v, tag);
    drive('hE000, v, tag);
    drive('hFFFF, v, tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    check_rd('hC018, 0, "R1");
    check_rd('hC01A, 0, "R1");
    check_rd('hC03A, 0, "R1");
    check_rd('hC03C, 0, "R1");
    drive('h1234, 1, "R1");
    // R2: idle, selects high
    sweep(0, "R2");
    // R3 R4 R5 R8: no merge, upper lines forced
    sweep(1, "R3_R4_R5_R8");
    // R9: writes, width masking, unmapped
    write_reg('hC018, 'hFFEA);
    check_rd('hC018, 'h2A, "R9");
    write_reg('hC01A, 'h0015);
    check_rd('hC01A, 'h15, "R9");
    write_reg('hC020, 'hFFFF);
    check_rd('hC018, 'h2A, "R9");
    check_rd('hC01A, 'h15, "R9");
    check_rd('hC03A, 0, "R9");
    check_rd('hC03C, 0, "R9");
    check_rd('hC020, 0, "R9");
    // R6 with forced upper lines (R8)
    sweep(1, "R6_R8");
    write_reg('hC03C, 'hFFFF);
    check_rd('hC03C, 1, "R9");
    // R6 R7: full address mapping
    sweep(1, "R6_R7");
    for (int m = 1; m < 4; m++) begin
      write_reg('hC03A, m | 'hFFFC);
      check_rd('hC03A, m, "R9");
      sweep(1, "R4_R5_merge");
      sweep(0, "R2_merge");
    end
    write_reg('hC03C, 0);
    drive('h9FFF, 1, "R8");
    drive('h0123, 1, "R8");
    repeat (3) @(posedge clk);
    done = 1;
    finish_run();
  end
endmodule